// File: doc/BRIEF.md
# Configurable Status Output Port

This block drives three general-purpose status pins of a time-triggered communication controller. Each pin picks one of three signal groups on its own. The protocol group shows remote pin voting, cluster sync-valid and protocol activity. The timing group follows an internal 16-bit time counter through tick and overflow pulses, and also shows the raw microtick strobe. The bus-guardian group shows the action-time signal and the gate-open state of each transmit channel. The protocol and guardian signals come from elsewhere in the controller as inputs.

Configuration is written through a small register write port into staging registers. None of it reaches the pins until the controller raises its init-done strobe, which copies the staged values into the active set. Until the first init-done after reset, every pin stays undriven, with output enable low and data low, so an external weak pull-down sets the level. Each pin is push-pull or open-drain. The output stage registers both the data and the enable of each pin, so the pins change only on a clock edge.

Top module: `status_port`

## Requirements
- R1: After reset and until the first init_done pulse, pin_oe and pin_out are all 0, even when configuration is written and the status inputs change.
- R2: Writes go to staging registers only. The pins follow a new configuration only after an init_done pulse, which applies all staged fields at once.
- R3: In protocol mode (mode code 0), pin 2 shows vote_in, pin 1 shows sync_ok and pin 0 shows proto_act, one clock after the inputs.
- R4: The swap bit (register 1, bit 3) exchanges the sources of pin 2 and pin 0 in protocol mode only. It has no effect on pins in other modes.
- R5: In timing mode (mode code 1), pin 0 shows a one-clock copy of each utick_in strobe, two clocks after the strobe.
- R6: In timing mode, pin 1 pulses for one clock each time the time counter increments. The counter increments once every (D+1) utick_in strobes, where D is register 2, bits 7:0. init_done clears both the counter and the prescaler.
- R7: In timing mode, pin 2 pulses for one clock when the 16-bit time counter wraps from 0xFFFF to 0. With D=0 and a strobe on every clock, this is the 65536th increment after init_done.
- R8: In bus-guardian mode (mode code 2), pin 2 shows act_time, pin 1 shows gate_open[1] and pin 0 shows gate_open[0].
- R9: A push-pull pin (its open-drain bit is 0) has pin_oe = 1 and pin_out equal to the selected value.
- R10: An open-drain pin (register 1, bit i = 1 for pin i) always has pin_out = 0, with pin_oe = 1 exactly when the selected value is 0.
- R11: Mode code 3 leaves the pin undriven (pin_oe = 0, pin_out = 0). Register 0 holds the mode code of pin i in bits 2i+1:2i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 modes, 1 open-drain and swap, 2 prescaler |
| cfg_wdata | input | 8 | Register write data |
| init_done | input | 1 | Applies the staged configuration and restarts the timebase |
| utick_in | input | 1 | Microtick strobe, one clock wide |
| vote_in | input | 1 | Remote pin voting status |
| sync_ok | input | 1 | Cluster synchronization valid |
| proto_act | input | 1 | Protocol activity |
| act_time | input | 1 | Bus-guardian action time |
| gate_open | input | 2 | Transmitter gate open, one bit per channel |
| pin_out | output | 3 | Pin data |
| pin_oe | output | 3 | Pin output enable |

## Verification
The checker looks at every cycle. It checks that the pins stay undriven before the first init_done, that no pin drives a high level while its applied configuration is open-drain, and that no pin drives data without its enable. It also checks that the active configuration never changes except after init_done, that each tick pulse follows a microtick strobe, and that every overflow pulse coincides with a tick. The bench scenarios cover the rest. They show the per-mode pin mapping, the swap exchange, the prescaler ratio, the exact cycle of the first overflow, and the two-clock microtick latency. None of these can be checked without knowing the stimulus.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int PIN_COUNT = 3;
  localparam int MODE_W    = 2;

  typedef enum logic [MODE_W-1:0] {
    GRP_PROTO = 2'd0,
    GRP_TIME  = 2'd1,
    GRP_GUARD = 2'd2,
    GRP_OFF   = 2'd3
  } grp_e;

  localparam logic [1:0] REG_MODE  = 2'd0;
  localparam logic [1:0] REG_DRIVE = 2'd1;
  localparam logic [1:0] REG_DIV   = 2'd2;
  localparam int SWAP_BIT = PIN_COUNT;
endpackage

// File: rtl/sp_cfg_regs.sv
module sp_cfg_regs
  import sp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [1:0]                  cfg_addr,
  input  logic [7:0]                  cfg_wdata,
  input  logic                        init_done,
  output logic                        active,
  output logic [PIN_COUNT*MODE_W-1:0] mode_act,
  output logic [PIN_COUNT-1:0]        od_act,
  output logic                        swap_act,
  output logic [DIV_W-1:0]            div_act
);
  localparam int MW = PIN_COUNT * MODE_W;

  logic [MW-1:0]        stg_mode_q, stg_mode_d;
  logic [PIN_COUNT-1:0] stg_od_q, stg_od_d;
  logic                 stg_swap_q, stg_swap_d;
  logic [DIV_W-1:0]     stg_div_q, stg_div_d;

  logic [MW-1:0]        act_mode_q, act_mode_d;
  logic [PIN_COUNT-1:0] act_od_q, act_od_d;
  logic                 act_swap_q, act_swap_d;
  logic [DIV_W-1:0]     act_div_q, act_div_d;
  logic                 active_q, active_d;

  always_comb begin
    stg_mode_d = stg_mode_q;
    stg_od_d   = stg_od_q;
    stg_swap_d = stg_swap_q;
    stg_div_d  = stg_div_q;
    if (cfg_we) begin
      unique case (cfg_addr)
        REG_MODE:  stg_mode_d = cfg_wdata[MW-1:0];
        REG_DRIVE: begin
          stg_od_d   = cfg_wdata[PIN_COUNT-1:0];
          stg_swap_d = cfg_wdata[SWAP_BIT];
        end
        REG_DIV:   stg_div_d = cfg_wdata[DIV_W-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    act_mode_d = act_mode_q;
    act_od_d   = act_od_q;
    act_swap_d = act_swap_q;
    act_div_d  = act_div_q;
    active_d   = active_q;
    if (init_done) begin
      act_mode_d = stg_mode_q;
      act_od_d   = stg_od_q;
      act_swap_d = stg_swap_q;
      act_div_d  = stg_div_q;
      active_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_mode_q <= {PIN_COUNT{GRP_OFF}};
      stg_od_q   <= '0;
      stg_swap_q <= 1'b0;
      stg_div_q  <= '0;
      act_mode_q <= {PIN_COUNT{GRP_OFF}};
      act_od_q   <= '0;
      act_swap_q <= 1'b0;
      act_div_q  <= '0;
      active_q   <= 1'b0;
    end else begin
      stg_mode_q <= stg_mode_d;
      stg_od_q   <= stg_od_d;
      stg_swap_q <= stg_swap_d;
      stg_div_q  <= stg_div_d;
      act_mode_q <= act_mode_d;
      act_od_q   <= act_od_d;
      act_swap_q <= act_swap_d;
      act_div_q  <= act_div_d;
      active_q   <= active_d;
    end
  end

  assign active   = active_q;
  assign mode_act = act_mode_q;
  assign od_act   = act_od_q;
  assign swap_act = act_swap_q;
  assign div_act  = act_div_q;
endmodule

// File: rtl/sp_timebase.sv
module sp_timebase #(
  parameter int TIME_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  input  logic             utick_in,
  output logic             micro_p,
  output logic             tick_p,
  output logic             ovf_p
);
  localparam logic [TIME_W-1:0] TIME_MAX = {TIME_W{1'b1}};

  logic [DIV_W-1:0]  pcnt_q, pcnt_d;
  logic [TIME_W-1:0] tcnt_q, tcnt_d;
  logic              micro_q, micro_d;
  logic              tick_q, tick_d;
  logic              ovf_q, ovf_d;
  logic              step_en;
  logic              inc_en;

  assign step_en = run && utick_in && !restart;
  assign inc_en  = step_en && (pcnt_q == div);

  always_comb begin
    pcnt_d  = pcnt_q;
    tcnt_d  = tcnt_q;
    micro_d = step_en;
    tick_d  = inc_en;
    ovf_d   = inc_en && (tcnt_q == TIME_MAX);
    if (restart) begin
      pcnt_d = '0;
      tcnt_d = '0;
    end else if (step_en) begin
      if (inc_en) begin
        pcnt_d = '0;
        tcnt_d = tcnt_q + 1'b1;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q  <= '0;
      tcnt_q  <= '0;
      micro_q <= 1'b0;
      tick_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      pcnt_q  <= pcnt_d;
      tcnt_q  <= tcnt_d;
      micro_q <= micro_d;
      tick_q  <= tick_d;
      ovf_q   <= ovf_d;
    end
  end

  assign micro_p = micro_q;
  assign tick_p  = tick_q;
  assign ovf_p   = ovf_q;
endmodule

// File: rtl/sp_pin_drv.sv
module sp_pin_drv
  import sp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  grp_e mode,
  input  logic open_drain,
  input  logic proto_b,
  input  logic time_b,
  input  logic guard_b,
  output logic pin_o,
  output logic pin_en
);
  logic sel_val;
  logic out_q, out_d;
  logic oe_q, oe_d;

  always_comb begin
    unique case (mode)
      GRP_PROTO: sel_val = proto_b;
      GRP_TIME:  sel_val = time_b;
      GRP_GUARD: sel_val = guard_b;
      default:   sel_val = 1'b0;
    endcase
  end

  always_comb begin
    if (!active || mode == GRP_OFF) begin
      out_d = 1'b0;
      oe_d  = 1'b0;
    end else if (open_drain) begin
      out_d = 1'b0;
      oe_d  = !sel_val;
    end else begin
      out_d = sel_val;
      oe_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign pin_o  = out_q;
  assign pin_en = oe_q;
endmodule

// File: rtl/status_port.sv
module status_port
  import sp_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       init_done,
  input  logic       utick_in,
  input  logic       vote_in,
  input  logic       sync_ok,
  input  logic       proto_act,
  input  logic       act_time,
  input  logic [1:0] gate_open,
  output logic [2:0] pin_out,
  output logic [2:0] pin_oe
);
  logic                        active;
  logic [PIN_COUNT*MODE_W-1:0] mode_act;
  logic [PIN_COUNT-1:0]        od_act;
  logic                        swap_act;
  logic [DIV_W-1:0]            div_act;
  logic                        micro_p, tick_p, ovf_p;
  logic [PIN_COUNT-1:0]        proto_vec, time_vec, guard_vec;

  sp_cfg_regs #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .init_done(init_done), .active(active),
    .mode_act(mode_act), .od_act(od_act), .swap_act(swap_act),
    .div_act(div_act)
  );

  sp_timebase #(.TIME_W(TIME_W), .DIV_W(DIV_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(active), .restart(init_done),
    .div(div_act), .utick_in(utick_in), .micro_p(micro_p),
    .tick_p(tick_p), .ovf_p(ovf_p)
  );

  always_comb begin
    proto_vec[2] = swap_act ? proto_act : vote_in;
    proto_vec[1] = sync_ok;
    proto_vec[0] = swap_act ? vote_in : proto_act;
    time_vec     = {ovf_p, tick_p, micro_p};
    guard_vec    = {act_time, gate_open[1], gate_open[0]};
  end

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    sp_pin_drv u_pin (
      .clk(clk), .rst_n(rst_n), .active(active),
      .mode(grp_e'(mode_act[MODE_W*i +: MODE_W])),
      .open_drain(od_act[i]), .proto_b(proto_vec[i]),
      .time_b(time_vec[i]), .guard_b(guard_vec[i]),
      .pin_o(pin_out[i]), .pin_en(pin_oe[i])
    );
  end
endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       init_done,
  input logic       utick_in,
  input logic [2:0] pin_out,
  input logic [2:0] pin_oe,
  input logic [2:0] od_act,
  input logic [5:0] mode_act,
  input logic       tick_p,
  input logic       ovf_p
);
  logic seen_init_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_init_q <= 1'b0;
    else if (init_done) seen_init_q <= 1'b1;
  end

  assert_idle_before_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_init_q |-> (pin_oe == 3'b000 && pin_out == 3'b000));

  assert_cfg_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(init_done) |-> ($stable(mode_act) && $stable(od_act)));

  assert_tick_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_p |-> $past(utick_in));

  assert_wrap_is_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_p |-> tick_p);

  assert_data_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == 3'b000);

  assert_od_never_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & $past(od_act)) == 3'b000);
endmodule

bind status_port sp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .utick_in(utick_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .od_act(od_act),
  .mode_act(mode_act), .tick_p(tick_p), .ovf_p(ovf_p)
);

// File: tb/status_port_bench.sv
module status_port_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       init_done;
  logic       utick_in;
  logic       vote_in, sync_ok, proto_act, act_time;
  logic [1:0] gate_open;
  logic [2:0] pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  status_port u_status_port (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .init_done(init_done), .utick_in(utick_in),
    .vote_in(vote_in), .sync_ok(sync_ok), .proto_act(proto_act),
    .act_time(act_time), .gate_open(gate_open), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  // {modes[5:0], od[2:0], swap, vote,sync,act,atime,g1,g0, exp_out[2:0], exp_oe[2:0]}
  // 0:R3 R9  1:R4  2:R8  3:R8 R10  4:R11 mixed  5:R4 no effect in guardian
  // 6:R5 idle timing  7:R10 single open-drain pin
  localparam int NV = 8;
  localparam logic [21:0] VEC [NV] = '{
    {6'b000000, 3'b000, 1'b0, 6'b101000, 3'b101, 3'b111},
    {6'b000000, 3'b000, 1'b1, 6'b110000, 3'b011, 3'b111},
    {6'b101010, 3'b000, 1'b0, 6'b000101, 3'b101, 3'b111},
    {6'b101010, 3'b111, 1'b0, 6'b000010, 3'b000, 3'b101},
    {6'b100011, 3'b000, 1'b0, 6'b010100, 3'b110, 3'b110},
    {6'b101010, 3'b000, 1'b1, 6'b000001, 3'b001, 3'b111},
    {6'b010101, 3'b000, 1'b0, 6'b111111, 3'b000, 3'b111},
    {6'b000000, 3'b010, 1'b0, 6'b001000, 3'b001, 3'b111}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic apply();
    init_done = 1'b1;
    step();
    init_done = 1'b0;
    step();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<190000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int micro_n, tick_n, ovf_n, ovf_at;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    init_done = 1'b0; utick_in = 1'b0;
    {vote_in, sync_ok, proto_act, act_time, gate_open} = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1: reset state and writes without init_done
    chk("R1 reset oe", pin_oe, 0);
    chk("R1 reset out", pin_out, 0);
    wr(2'd0, 8'h00);
    vote_in = 1'b1; proto_act = 1'b1; sync_ok = 1'b1;
    repeat (3) step();
    chk("R1 no init oe", pin_oe, 0);
    chk("R1 no init out", pin_out, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [21:0] e;
      e = VEC[v];
      wr(2'd0, {2'b00, e[21:16]});
      wr(2'd1, {4'b0000, e[12], e[15:13]});
      {vote_in, sync_ok, proto_act, act_time, gate_open} = e[11:6];
      apply();
      chk($sformatf("R3/R4/R5/R8/R9/R10/R11 vec%0d out", v), pin_out, e[5:3]);
      chk($sformatf("R3/R4/R5/R8/R9/R10/R11 vec%0d oe", v), pin_oe, e[2:0]);
    end

    // R2: staged write does not reach pins until init_done
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    {vote_in, sync_ok, proto_act, act_time, gate_open} = 6'b100_011;
    apply();
    chk("R2 protocol applied", pin_out, 3'b100);
    wr(2'd0, 8'h2A);
    repeat (3) step();
    chk("R2 staged not live", pin_out, 3'b100);
    apply();
    chk("R2 guardian after init", pin_out, 3'b011);

    // R3: one-clock latency of a protocol input
    wr(2'd0, 8'h00);
    {vote_in, sync_ok, proto_act, act_time, gate_open} = '0;
    apply();
    sync_ok = 1'b1;
    @(posedge clk); #1;
    chk("R3 latency", pin_out, 3'b010);

    // R5: microtick latency, timing mode all pins, D=2
    @(negedge clk);
    sync_ok = 1'b0;
    wr(2'd0, 8'h15);
    wr(2'd2, 8'h02);
    apply();
    utick_in = 1'b1;
    step();
    utick_in = 1'b0;
    chk("R5 micro +1", pin_out[0], 0);
    step();
    chk("R5 micro +2", pin_out[0], 1);
    step();
    chk("R5 micro +3", pin_out[0], 0);

    // R6: prescaler ratio D=2 after restart
    apply();
    micro_n = 0; tick_n = 0;
    for (int k = 0; k < 9; k++) begin
      utick_in = 1'b1;
      step();
      micro_n += pin_out[0]; tick_n += pin_out[1];
    end
    utick_in = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step();
      micro_n += pin_out[0]; tick_n += pin_out[1];
    end
    chk("R5 micro count", micro_n, 9);
    chk("R6 tick count D=2", tick_n, 3);

    // R7: wrap on the 65536th increment with D=0
    wr(2'd2, 8'h00);
    apply();
    ovf_n = 0; tick_n = 0; ovf_at = 0;
    for (int k = 1; k <= 65540; k++) begin
      utick_in = 1'b1;
      step();
      tick_n += pin_out[1];
      if (pin_out[2]) begin
        ovf_n++;
        if (ovf_at == 0) ovf_at = k;
      end
    end
    utick_in = 1'b0;
    step();
    tick_n += pin_out[1];
    chk("R7 overflow count", ovf_n, 1);
    chk("R7 overflow position", ovf_at, 65537);
    chk("R6 tick count D=0", tick_n, 65540);

    // R1: reset again returns pins to undriven
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    chk("R1 second reset oe", pin_oe, 0);

    finish_run();
  end
endmodule